// File: doc/BRIEF.md
# Interrupt-Capable General-Purpose Pin Bank

This block drives and senses a bank of up to 32 general-purpose pins, configured and observed through a small memory-mapped register set with 32-bit data. Every pin can act as a plain input, a driven output, or an interrupt source. Configuration is held per pin, one bit per pin in each register.

An interrupt source can watch for a high or a low level, or for a rising edge, a falling edge, or both edges. The pin is resynchronised and can optionally be debounced before detection. Level-sensed status tracks the pin. Edge-sensed status is held until software writes a one to clear it. Each pin has an enable bit, and the enabled pending bits are ORed onto a single level interrupt line.

Software writes go in on the cycle of a write strobe. Read data is combinational from the address. Pin output value and output enable are presented directly to the pads.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset every configuration register, every enable bit and every status bit is 0, so `pin_oe` and `irq_out` are 0.
- R2: Offset 0x00 selects per pin interrupt mode (1) or general I/O mode (0). Offset 0x04 selects output (1) or input (0), and offset 0x08 holds output data. `pin_out` equals the data register, and `pin_oe` is set for a pin exactly when its direction bit is 1 and its mode bit is 0.
- R3: A read of offset 0x0C returns the synchronised pin levels, which reflect `pin_in` within three clock cycles.
- R4: Writing 1 to a bit at offset 0x1C enables that pin's interrupt. Writing 0 to a bit at offset 0x18 disables it, and writing 1 there has no effect. A read of 0x18 returns the enable bits.
- R5: `irq_out` is high while any pin has both its status bit (read at offset 0x10) and its enable bit set. A disabled pin keeps its status.
- R6: With edge select (offset 0x24) at 0, an interrupt pin's status follows its active level. Polarity (offset 0x20) 0 means high and 1 means low. A clear write has no lasting effect while the level persists.
- R7: With edge select at 1 and both-edge at 0, the status latches on a rising edge (polarity 0) or a falling edge (polarity 1). It stays set until a 1 is written to that bit at offset 0x14. Writing 0 there leaves it unchanged.
- R8: With both-edge select (offset 0x4C) at 1, an edge-mode pin latches status on rising and on falling edges.
- R9: A pin whose mode bit is 0 never sets its status bit, whatever its input does.
- R10: With the debounce bit (offset 0x28) set, a new pin level is accepted only after it has been stable for DEB_COUNT consecutive sample ticks, so a pulse of two clocks raises no status. With the bit clear, the same pulse latches edge status.
- R11: Offsets 0x14 and 0x1C read as 0. The status register at 0x10 cannot be written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 7 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| pin_in | input | NPINS | Pad input levels |
| pin_out | output | NPINS | Pad output values |
| pin_oe | output | NPINS | Pad output enables |
| irq_out | output | 1 | Combined level interrupt |

## Verification
The assertions assume that `bus_wr` is a single-cycle strobe with stable address and data. They also assume that `rst_n` is asserted before the first clock edge, and that `pin_in` changes only away from the rising edge. The stimulus drives every input on the falling edge, issues one register access at a time, and holds each pin level for at least two cycles. After each pin change it waits well beyond the synchroniser, filter and status register latency before reading, so every expected value is settled and no check depends on exact arrival cycles.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
    localparam int ADDR_W = 7;

    localparam logic [ADDR_W-1:0] OFS_MODE   = 7'h00;
    localparam logic [ADDR_W-1:0] OFS_DIR    = 7'h04;
    localparam logic [ADDR_W-1:0] OFS_DOUT   = 7'h08;
    localparam logic [ADDR_W-1:0] OFS_DIN    = 7'h0C;
    localparam logic [ADDR_W-1:0] OFS_STAT   = 7'h10;
    localparam logic [ADDR_W-1:0] OFS_CLR    = 7'h14;
    localparam logic [ADDR_W-1:0] OFS_MASK   = 7'h18;
    localparam logic [ADDR_W-1:0] OFS_UNMASK = 7'h1C;
    localparam logic [ADDR_W-1:0] OFS_POL    = 7'h20;
    localparam logic [ADDR_W-1:0] OFS_EDGE   = 7'h24;
    localparam logic [ADDR_W-1:0] OFS_DEB    = 7'h28;
    localparam logic [ADDR_W-1:0] OFS_BOTH   = 7'h4C;
endpackage

// File: rtl/gpio_reg_file.sv
module gpio_reg_file
    import gpio_bank_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [NPINS-1:0]  din,
    input  logic [NPINS-1:0]  stat,
    output logic [NPINS-1:0]  mode,
    output logic [NPINS-1:0]  dir,
    output logic [NPINS-1:0]  dout,
    output logic [NPINS-1:0]  pol,
    output logic [NPINS-1:0]  edg,
    output logic [NPINS-1:0]  both,
    output logic [NPINS-1:0]  deb,
    output logic [NPINS-1:0]  en,
    output logic [NPINS-1:0]  clr
);
    typedef struct packed {
        logic [NPINS-1:0] mode;
        logic [NPINS-1:0] dir;
        logic [NPINS-1:0] dout;
        logic [NPINS-1:0] pol;
        logic [NPINS-1:0] edg;
        logic [NPINS-1:0] both;
        logic [NPINS-1:0] deb;
        logic [NPINS-1:0] en;
    } cfg_t;

    cfg_t             cfg_q;
    cfg_t             cfg_d;
    logic [NPINS-1:0] wd;
    logic [NPINS-1:0] clr_d;
    logic [NPINS-1:0] rd;

    assign wd = bus_wdata[NPINS-1:0];

    always_comb begin
        cfg_d = cfg_q;
        clr_d = '0;
        if (bus_wr) begin
            case (bus_addr)
                OFS_MODE:   cfg_d.mode = wd;
                OFS_DIR:    cfg_d.dir  = wd;
                OFS_DOUT:   cfg_d.dout = wd;
                OFS_POL:    cfg_d.pol  = wd;
                OFS_EDGE:   cfg_d.edg  = wd;
                OFS_BOTH:   cfg_d.both = wd;
                OFS_DEB:    cfg_d.deb  = wd;
                OFS_MASK:   cfg_d.en   = cfg_q.en & wd;
                OFS_UNMASK: cfg_d.en   = cfg_q.en | wd;
                OFS_CLR:    clr_d      = wd;
                default:    ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    always_comb begin
        rd = '0;
        case (bus_addr)
            OFS_MODE: rd = cfg_q.mode;
            OFS_DIR:  rd = cfg_q.dir;
            OFS_DOUT: rd = cfg_q.dout;
            OFS_DIN:  rd = din;
            OFS_STAT: rd = stat;
            OFS_MASK: rd = cfg_q.en;
            OFS_POL:  rd = cfg_q.pol;
            OFS_EDGE: rd = cfg_q.edg;
            OFS_DEB:  rd = cfg_q.deb;
            OFS_BOTH: rd = cfg_q.both;
            default:  rd = '0;
        endcase
        bus_rdata            = '0;
        bus_rdata[NPINS-1:0] = rd;
    end

    assign mode = cfg_q.mode;
    assign dir  = cfg_q.dir;
    assign dout = cfg_q.dout;
    assign pol  = cfg_q.pol;
    assign edg  = cfg_q.edg;
    assign both = cfg_q.both;
    assign deb  = cfg_q.deb;
    assign en   = cfg_q.en;
    assign clr  = clr_d;
endmodule

// File: rtl/gpio_pin_filter.sv
module gpio_pin_filter #(
    parameter int DEB_COUNT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic tick,
    input  logic deb_en,
    output logic level
);
    localparam int CW = (DEB_COUNT > 2) ? $clog2(DEB_COUNT) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(DEB_COUNT - 1);

    typedef struct packed {
        logic          s1;
        logic          s2;
        logic          filt;
        logic [CW-1:0] cnt;
    } flt_t;

    flt_t flt_q;
    flt_t flt_d;

    always_comb begin
        flt_d    = flt_q;
        flt_d.s1 = pin;
        flt_d.s2 = flt_q.s1;
        if (!deb_en) begin
            flt_d.filt = flt_q.s2;
            flt_d.cnt  = '0;
        end else if (flt_q.s2 == flt_q.filt) begin
            flt_d.cnt = '0;
        end else if (tick) begin
            if (flt_q.cnt == CNT_LAST) begin
                flt_d.filt = flt_q.s2;
                flt_d.cnt  = '0;
            end else begin
                flt_d.cnt = flt_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flt_q <= '0;
        else        flt_q <= flt_d;
    end

    assign level = flt_q.filt;
endmodule

// File: rtl/gpio_irq_sense.sv
module gpio_irq_sense #(
    parameter int NPINS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] filt,
    input  logic [NPINS-1:0] mode,
    input  logic [NPINS-1:0] edg,
    input  logic [NPINS-1:0] pol,
    input  logic [NPINS-1:0] both,
    input  logic [NPINS-1:0] clr,
    output logic [NPINS-1:0] stat
);
    typedef struct packed {
        logic [NPINS-1:0] prev;
        logic [NPINS-1:0] stat;
    } sense_t;

    sense_t           sn_q;
    sense_t           sn_d;
    logic [NPINS-1:0] rise;
    logic [NPINS-1:0] fall;
    logic [NPINS-1:0] hit;
    logic [NPINS-1:0] lvl;

    always_comb begin
        rise      = filt & ~sn_q.prev;
        fall      = ~filt & sn_q.prev;
        hit       = (both & (rise | fall)) |
                    (~both & ((~pol & rise) | (pol & fall)));
        lvl       = filt ^ pol;
        sn_d.prev = filt;
        sn_d.stat = mode & ((~edg & lvl) |
                            (edg & ((sn_q.stat & ~clr) | hit)));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sn_q <= '0;
        else        sn_q <= sn_d;
    end

    assign stat = sn_q.stat;
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
    import gpio_bank_pkg::*;
#(
    parameter int NPINS     = 32,
    parameter int DEB_COUNT = 4,
    parameter int TICK_DIV  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pin_out,
    output logic [NPINS-1:0]  pin_oe,
    output logic              irq_out
);
    localparam int TW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
    localparam logic [TW-1:0] TICK_LAST = TW'(TICK_DIV - 1);

    logic [NPINS-1:0] cfg_mode;
    logic [NPINS-1:0] cfg_dir;
    logic [NPINS-1:0] cfg_dout;
    logic [NPINS-1:0] cfg_pol;
    logic [NPINS-1:0] cfg_edg;
    logic [NPINS-1:0] cfg_both;
    logic [NPINS-1:0] cfg_deb;
    logic [NPINS-1:0] irq_en;
    logic [NPINS-1:0] irq_clr;
    logic [NPINS-1:0] irq_stat;
    logic [NPINS-1:0] pin_filt;
    logic [TW-1:0]    tick_q;
    logic [TW-1:0]    tick_d;
    logic             tick;

    always_comb begin
        tick   = (tick_q == TICK_LAST);
        tick_d = tick ? '0 : tick_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tick_q <= '0;
        else        tick_q <= tick_d;
    end

    gpio_reg_file #(.NPINS(NPINS)) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .din       (pin_filt),
        .stat      (irq_stat),
        .mode      (cfg_mode),
        .dir       (cfg_dir),
        .dout      (cfg_dout),
        .pol       (cfg_pol),
        .edg       (cfg_edg),
        .both      (cfg_both),
        .deb       (cfg_deb),
        .en        (irq_en),
        .clr       (irq_clr)
    );

    for (genvar gi = 0; gi < NPINS; gi++) begin : g_pin
        gpio_pin_filter #(.DEB_COUNT(DEB_COUNT)) flt_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .pin    (pin_in[gi]),
            .tick   (tick),
            .deb_en (cfg_deb[gi]),
            .level  (pin_filt[gi])
        );
    end

    gpio_irq_sense #(.NPINS(NPINS)) sense_i (
        .clk   (clk),
        .rst_n (rst_n),
        .filt  (pin_filt),
        .mode  (cfg_mode),
        .edg   (cfg_edg),
        .pol   (cfg_pol),
        .both  (cfg_both),
        .clr   (irq_clr),
        .stat  (irq_stat)
    );

    assign pin_out = cfg_dout;
    assign pin_oe  = cfg_dir & ~cfg_mode;
    assign irq_out = |(irq_stat & irq_en);
endmodule

// File: rtl/gpio_irq_bank_chk.sv
module gpio_irq_bank_chk
    import gpio_bank_pkg::*;
#(
    parameter int NPINS = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [NPINS-1:0]  pin_oe,
    input logic [NPINS-1:0]  cfg_mode,
    input logic [NPINS-1:0]  cfg_edg,
    input logic [NPINS-1:0]  irq_en,
    input logic [NPINS-1:0]  irq_stat
);
    logic [NPINS-1:0] wd;
    logic [NPINS-1:0] clr_vec;

    assign wd      = bus_wdata[NPINS-1:0];
    assign clr_vec = (bus_wr && bus_addr == OFS_CLR) ? wd : '0;

    AST_MASK_WRITE_DISABLES: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_MASK) |=> ((irq_en & ~$past(wd)) == '0)); // R4

    AST_UNMASK_WRITE_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_UNMASK) |=> ((irq_en & $past(wd)) == $past(wd))); // R4

    AST_OE_FOLLOWS_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_DIR) |=> ((pin_oe & ~$past(wd)) == '0)); // R2

    AST_IO_PIN_NO_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_stat & ~$past(cfg_mode)) == '0); // R9

    AST_EDGE_STATUS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(irq_stat & cfg_mode & cfg_edg & ~clr_vec) & ~irq_stat) == '0)); // R7
endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(.NPINS(NPINS)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .pin_oe    (pin_oe),
    .cfg_mode  (cfg_mode),
    .cfg_edg   (cfg_edg),
    .irq_en    (irq_en),
    .irq_stat  (irq_stat)
);

// File: tb/gpio_irq_bank_tb_top.sv
module gpio_irq_bank_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [6:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_out;
    logic [31:0] pin_oe;
    logic        irq_out;

    int    errors = 0;
    int    checks = 0;
    bit    done = 1'b0;
    string       tag_q[$];
    logic [31:0] exp_q[$];
    logic [31:0] act_q[$];

    always #5 clk = ~clk;

    gpio_irq_bank dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq_out(irq_out)
    );

    // monitor: pops expected and observed items and compares them
    always @(posedge clk) begin
        while (exp_q.size() > 0 && act_q.size() > 0) begin
            automatic string       t = tag_q.pop_front();
            automatic logic [31:0] e = exp_q.pop_front();
            automatic logic [31:0] a = act_q.pop_front();
            checks++;
            if (a !== e) begin
                errors++;
                $display("FAIL %s: got %08h expected %08h", t, a, e);
            end
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [6:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic expect_val(input logic [31:0] got, input logic [31:0] exp, input string tag);
        tag_q.push_back(tag);
        exp_q.push_back(exp);
        act_q.push_back(got);
    endtask

    task automatic expect_rd(input logic [6:0] a, input logic [31:0] msk,
                             input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_addr = a;
        #1;
        expect_val(bus_rdata & msk, exp & msk, tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(2);
        // R1 reset state
        expect_rd(7'h00, 32'hFFFFFFFF, 32'h0, "R1 mode reg");
        expect_rd(7'h04, 32'hFFFFFFFF, 32'h0, "R1 dir reg");
        expect_rd(7'h10, 32'hFFFFFFFF, 32'h0, "R1 status");
        expect_rd(7'h18, 32'hFFFFFFFF, 32'h0, "R1 enables");
        expect_val({31'd0, irq_out}, 32'h0, "R1 irq_out");
        expect_val(pin_oe, 32'h0, "R1 pin_oe");

        // R2 direction and output data
        wr(7'h04, 32'h000000F0);
        wr(7'h08, 32'h000000A5);
        wait_cyc(1);
        expect_val(pin_oe, 32'h000000F0, "R2 pin_oe");
        expect_val(pin_out, 32'h000000A5, "R2 pin_out");
        wr(7'h00, 32'h00000010);
        wait_cyc(1);
        expect_val(pin_oe, 32'h000000E0, "R2 irq mode forces input");

        // R3 input data
        pin_in = 32'h12340000;
        wait_cyc(4);
        expect_rd(7'h0C, 32'hFFFFFFFF, 32'h12340000, "R3 input data");
        pin_in = '0;
        wait_cyc(4);

        // R11 write-only and read-only
        expect_rd(7'h14, 32'hFFFFFFFF, 32'h0, "R11 clear reads 0");
        expect_rd(7'h1C, 32'hFFFFFFFF, 32'h0, "R11 unmask reads 0");
        wr(7'h10, 32'hFFFFFFFF);
        expect_rd(7'h10, 32'hFFFFFFFF, 32'h0, "R11 status not writable");

        // R4 enables
        wr(7'h1C, 32'h00000F00);
        expect_rd(7'h18, 32'hFFFFFFFF, 32'h00000F00, "R4 unmask sets");
        wr(7'h18, 32'hFFFFF7FF);
        expect_rd(7'h18, 32'hFFFFFFFF, 32'h00000700, "R4 mask zero clears");
        wr(7'h18, 32'hFFFFFFFF);
        expect_rd(7'h18, 32'hFFFFFFFF, 32'h00000700, "R4 mask one no effect");

        // R6 level sensing on pin 8
        wr(7'h00, 32'h00000100);
        pin_in[8] = 1'b1;
        wait_cyc(6);
        expect_rd(7'h10, 32'h00000100, 32'h00000100, "R6 level high sets");
        expect_val({31'd0, irq_out}, 32'h1, "R5 irq from level");
        wr(7'h14, 32'h00000100);
        wait_cyc(2);
        expect_rd(7'h10, 32'h00000100, 32'h00000100, "R6 clear no lasting effect");
        pin_in[8] = 1'b0;
        wait_cyc(6);
        expect_rd(7'h10, 32'h00000100, 32'h0, "R6 level gone");
        expect_val({31'd0, irq_out}, 32'h0, "R5 irq drops");
        wr(7'h20, 32'h00000100);
        wait_cyc(2);
        expect_rd(7'h10, 32'h00000100, 32'h00000100, "R6 active low sets");
        wr(7'h20, 32'h00000000);
        wait_cyc(2);

        // R7 edge sensing on pin 9
        wr(7'h00, 32'h00000300);
        wr(7'h24, 32'h00000200);
        wait_cyc(2);
        pin_in[9] = 1'b1;
        wait_cyc(6);
        pin_in[9] = 1'b0;
        wait_cyc(6);
        expect_rd(7'h10, 32'h00000300, 32'h00000200, "R7 rising latched");
        wr(7'h14, 32'h00000000);
        expect_rd(7'h10, 32'h00000200, 32'h00000200, "R7 clear zero no effect");
        wr(7'h14, 32'h00000200);
        expect_rd(7'h10, 32'h00000200, 32'h0, "R7 clear one");
        wr(7'h20, 32'h00000200);
        pin_in[9] = 1'b1;
        wait_cyc(6);
        expect_rd(7'h10, 32'h00000200, 32'h0, "R7 falling mode ignores rise");
        pin_in[9] = 1'b0;
        wait_cyc(6);
        expect_rd(7'h10, 32'h00000200, 32'h00000200, "R7 falling latched");
        wr(7'h14, 32'h00000200);

        // R5 enable gating on pin 10
        wr(7'h00, 32'h00000700);
        wr(7'h24, 32'h00000600);
        pin_in[10] = 1'b1;
        wait_cyc(6);
        expect_val({31'd0, irq_out}, 32'h1, "R5 enabled pending");
        wr(7'h18, 32'hFFFFFBFF);
        wait_cyc(1);
        expect_val({31'd0, irq_out}, 32'h0, "R5 disabled no irq");
        expect_rd(7'h10, 32'h00000400, 32'h00000400, "R5 status kept");
        wr(7'h1C, 32'h00000400);
        wait_cyc(1);
        expect_val({31'd0, irq_out}, 32'h1, "R5 re-enabled");
        wr(7'h14, 32'h00000400);
        wait_cyc(1);
        expect_val({31'd0, irq_out}, 32'h0, "R5 cleared");

        // R8 both edges on pin 12
        wr(7'h00, 32'h00001700);
        wr(7'h24, 32'h00001600);
        wr(7'h4C, 32'h00001000);
        pin_in[12] = 1'b1;
        wait_cyc(6);
        expect_rd(7'h10, 32'h00001000, 32'h00001000, "R8 rising");
        wr(7'h14, 32'h00001000);
        pin_in[12] = 1'b0;
        wait_cyc(6);
        expect_rd(7'h10, 32'h00001000, 32'h00001000, "R8 falling");
        wr(7'h14, 32'h00001000);

        // R9 I/O mode pin 13
        pin_in[13] = 1'b1;
        wait_cyc(6);
        pin_in[13] = 1'b0;
        wait_cyc(6);
        expect_rd(7'h10, 32'h00002000, 32'h0, "R9 io pin no status");

        // R10 debounce on pin 5, none on pin 6
        wr(7'h00, 32'h00001760);
        wr(7'h24, 32'h00001660);
        wr(7'h28, 32'h00000020);
        wait_cyc(4);
        pin_in[5] = 1'b1; pin_in[6] = 1'b1;
        wait_cyc(2);
        pin_in[5] = 1'b0; pin_in[6] = 1'b0;
        wait_cyc(30);
        expect_rd(7'h10, 32'h00000060, 32'h00000040, "R10 glitch filtered");
        pin_in[5] = 1'b1;
        wait_cyc(40);
        expect_rd(7'h10, 32'h00000020, 32'h00000020, "R10 stable accepted");

        wait_cyc(3);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule